// File: doc/BRIEF.md
# Delay-Slot Branch Target Unit

This unit resolves control transfers for a 64-bit pipeline whose branches carry one delay slot. For each accepted jump or conditional branch it decides whether control transfers, forms the redirect address measured from the delay-slot instruction (PC+4), and records it as the pending redirect. It also reports when the delay-slot instruction must be squashed, which happens for a likely branch that falls through. It produces the return-address write for the linking forms.

A small two-state machine sequences the work. In ST_IDLE an asserted `in_valid` is accepted. The transition IDLE_TO_PEND fires when the accepted instruction transfers control. The transition IDLE_STAY fires when it falls through. In ST_PEND the redirect is held until the front end consumes it with `redirect_ack`, which fires the transition PEND_TO_IDLE. Without an acknowledge, PEND_HOLD keeps the state in ST_PEND. Every result is registered and appears one cycle after acceptance, marked by a single-cycle `out_valid` strobe.

Top module: `dsb_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_pending`, `out_annul` and `out_link_we` are 0, and `out_target`, `out_link_idx` and `out_link_val` are all zero.
- R2: For `in_kind`=0 (jump), the target is bits [63:28] of PC+4, followed by `in_field[25:0]`, followed by two zero bits. A jump is always taken.
- R3: For `in_kind`=1 (jump and link), the target is formed as in R2. In addition, `out_link_we` is 1, `out_link_idx` is 31 and `out_link_val` is PC+8, regardless of `in_link`.
- R4: For relative branches, the target is PC + 4 + the sign extension of {`in_field[15:0]`, 2'b00}. Bit 15 of the immediate fills bits [63:18], and the sum wraps modulo 2^64.
- R5: For `in_kind`=2 (equality branch), the branch is taken exactly when (`in_rs` == `in_rt`) XOR `in_ne`.
- R6: For `in_kind`=3 (compare with zero), `in_cmp` selects a signed test of `in_rs` against zero. The encodings are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than and 5 greater or equal. Codes 6 and 7 are never taken.
- R7: One cycle after acceptance, `out_valid` pulses for one cycle. If control transfers, `out_pending` rises and `out_target` takes the new target. If the instruction falls through, `out_pending` stays 0 and `out_target` keeps its previous value.
- R8: `out_annul` is 1 with the strobe only for a conditional branch that has `in_likely` set and is not taken. It is 0 for taken branches, for non-likely branches and for jumps.
- R9: A compare-with-zero branch with `in_link` set writes PC+8 to register 31 whether it is taken or not. `in_link` has no effect on `in_kind` 0 or 2.
- R10: `out_pending` stays 1 until `redirect_ack` is sampled high, and it is 0 from the following cycle on.
- R11: While `out_pending` is 1, `in_valid` is ignored. No strobe follows, and `out_target` and the link outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded control-transfer instruction is present |
| in_pc | input | 64 | Address of the branch instruction |
| in_kind | input | 2 | 0 jump, 1 jump and link, 2 equality branch, 3 compare with zero |
| in_likely | input | 1 | Squash the delay slot when the branch is not taken |
| in_link | input | 1 | Link request for compare-with-zero branches |
| in_ne | input | 1 | Invert the equality test |
| in_cmp | input | 3 | Compare-with-zero condition code |
| in_field | input | 26 | Jump offset; bits [15:0] are the branch immediate |
| in_rs | input | 64 | First register operand |
| in_rt | input | 64 | Second register operand |
| redirect_ack | input | 1 | The front end has taken the pending redirect |
| out_valid | output | 1 | One-cycle result strobe |
| out_pending | output | 1 | A redirect is waiting to be consumed |
| out_annul | output | 1 | Squash the delay-slot instruction |
| out_target | output | 64 | Delayed redirect address |
| out_link_we | output | 1 | Write the return address |
| out_link_idx | output | 5 | Register index of the return-address write |
| out_link_val | output | 64 | Return address (PC+8) |

## Verification
The bench targets jumps whose delay slot lies in the next 256 MB region. A unit that used the branch's own PC for the upper bits would land 256 MB short. It also targets branch sums that wrap past the top of the address space, and the most negative immediate, where a missing +4 or a short sign extension gives a wrong target. For compare-with-zero it uses a register with only the sign bit set, so that an unsigned comparison would wrongly take a greater-than branch. It also checks that the reserved codes are never taken. Further cases cover likely branches that fall through or are taken, links on branches that fall through, link flags that must be ignored, a redirect held for several cycles without acknowledge, and new requests offered while a redirect is pending. A unit that overwrote the pending target or dropped the pending flag early would fail these.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    typedef enum logic [1:0] {
        BK_JUMP = 2'd0,
        BK_JAL  = 2'd1,
        BK_EQ   = 2'd2,
        BK_CMPZ = 2'd3
    } br_kind_e;

    typedef enum logic [2:0] {
        CZ_EQ   = 3'd0,
        CZ_NE   = 3'd1,
        CZ_LT   = 3'd2,
        CZ_LE   = 3'd3,
        CZ_GT   = 3'd4,
        CZ_GE   = 3'd5,
        CZ_RSV6 = 3'd6,
        CZ_RSV7 = 3'd7
    } cz_cond_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } dsb_state_e;

endpackage

// File: rtl/dsb_target_calc.sv
module dsb_target_calc #(
    parameter int XLEN  = 64,
    parameter int OFF_W = 26,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] field,
    input  logic             is_jump,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  link_val
);
    localparam int REGION_LSB = OFF_W + 2;
    localparam int EXT_W      = XLEN - IMM_W - 2;

    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rel_tgt;

    always_comb begin
        slot_pc  = pc + XLEN'(4);
        jump_tgt = {slot_pc[XLEN-1:REGION_LSB], field, 2'b00};
        imm_ext  = {{EXT_W{field[IMM_W-1]}}, field[IMM_W-1:0], 2'b00};
        rel_tgt  = slot_pc + imm_ext;
        target   = is_jump ? jump_tgt : rel_tgt;
        link_val = pc + XLEN'(8);
    end
endmodule

// File: rtl/dsb_cond_eval.sv
module dsb_cond_eval
    import dsb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_kind_e        kind,
    input  logic            ne,
    input  cz_cond_e        cond,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    output logic            taken
);
    logic is_zero;
    logic is_neg;
    logic cz_hit;

    always_comb begin
        is_zero = (rs == '0);
        is_neg  = rs[XLEN-1];
        unique case (cond)
            CZ_EQ:   cz_hit = is_zero;
            CZ_NE:   cz_hit = !is_zero;
            CZ_LT:   cz_hit = is_neg;
            CZ_LE:   cz_hit = is_neg || is_zero;
            CZ_GT:   cz_hit = !is_neg && !is_zero;
            CZ_GE:   cz_hit = !is_neg;
            CZ_RSV6: cz_hit = 1'b0;
            CZ_RSV7: cz_hit = 1'b0;
        endcase
        unique case (kind)
            BK_JUMP: taken = 1'b1;
            BK_JAL:  taken = 1'b1;
            BK_EQ:   taken = (rs == rt) ^ ne;
            BK_CMPZ: taken = cz_hit;
        endcase
    end
endmodule

// File: rtl/dsb_branch_unit.sv
module dsb_branch_unit
    import dsb_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int OFF_W    = 26,
    parameter int IMM_W    = 16,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [1:0]        in_kind,
    input  logic              in_likely,
    input  logic              in_link,
    input  logic              in_ne,
    input  logic [2:0]        in_cmp,
    input  logic [OFF_W-1:0]  in_field,
    input  logic [XLEN-1:0]   in_rs,
    input  logic [XLEN-1:0]   in_rt,
    input  logic              redirect_ack,
    output logic              out_valid,
    output logic              out_pending,
    output logic              out_annul,
    output logic [XLEN-1:0]   out_target,
    output logic              out_link_we,
    output logic [RIDX_W-1:0] out_link_idx,
    output logic [XLEN-1:0]   out_link_val
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    br_kind_e   kind;
    cz_cond_e   cond;
    dsb_state_e state_q, state_d;

    logic            accept;
    logic            taken;
    logic            is_jump;
    logic            is_cond;
    logic            link_req;
    logic [XLEN-1:0] tgt_calc;
    logic [XLEN-1:0] link_calc;

    logic            valid_q;
    logic            annul_q;
    logic            link_we_q;
    logic [XLEN-1:0] target_q;
    logic [XLEN-1:0] link_val_q;

    assign kind     = br_kind_e'(in_kind);
    assign cond     = cz_cond_e'(in_cmp);
    assign is_jump  = (kind == BK_JUMP) || (kind == BK_JAL);
    assign is_cond  = !is_jump;
    assign link_req = (kind == BK_JAL) || ((kind == BK_CMPZ) && in_link);
    assign accept   = in_valid && (state_q == ST_IDLE);

    dsb_target_calc #(
        .XLEN  (XLEN),
        .OFF_W (OFF_W),
        .IMM_W (IMM_W)
    ) u_tgt (
        .pc       (in_pc),
        .field    (in_field),
        .is_jump  (is_jump),
        .target   (tgt_calc),
        .link_val (link_calc)
    );

    dsb_cond_eval #(
        .XLEN (XLEN)
    ) u_cond (
        .kind  (kind),
        .ne    (in_ne),
        .cond  (cond),
        .rs    (in_rs),
        .rt    (in_rt),
        .taken (taken)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE_TO_PEND, IDLE_STAY, PEND_TO_IDLE, PEND_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && taken) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (redirect_ack) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            annul_q    <= 1'b0;
            link_we_q  <= 1'b0;
            target_q   <= '0;
            link_val_q <= '0;
        end else begin
            valid_q   <= accept;
            annul_q   <= accept && is_cond && in_likely && !taken;
            link_we_q <= accept && link_req;
            if (accept && taken) begin
                target_q <= tgt_calc;
            end
            if (accept && link_req) begin
                link_val_q <= link_calc;
            end
        end
    end

    assign out_valid    = valid_q;
    assign out_pending  = (state_q == ST_PEND);
    assign out_annul    = annul_q;
    assign out_target   = target_q;
    assign out_link_we  = link_we_q;
    assign out_link_idx = link_we_q ? LINK_IDX : '0;
    assign out_link_val = link_val_q;
endmodule

// File: rtl/dsb_branch_unit_chk.sv
module dsb_branch_unit_chk #(
    parameter int XLEN     = 64,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_ack,
    input logic              out_valid,
    input logic              out_pending,
    input logic              out_annul,
    input logic [XLEN-1:0]   out_target,
    input logic              out_link_we,
    input logic [RIDX_W-1:0] out_link_idx
);
    AST_PEND_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_pending) |-> out_valid); // R7

    AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_target)); // R7

    AST_ANNUL_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        out_annul |-> (out_valid && !out_pending)); // R8

    AST_LINK_REG31: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_valid && out_link_idx == RIDX_W'(LINK_REG))); // R3

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pending && !redirect_ack) |=> out_pending); // R10

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pending && redirect_ack) |=> !out_pending); // R10

    AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_pending |=> !out_valid); // R11
endmodule

bind dsb_branch_unit dsb_branch_unit_chk #(
    .XLEN     (XLEN),
    .RIDX_W   (RIDX_W),
    .LINK_REG (LINK_REG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect_ack (redirect_ack),
    .out_valid    (out_valid),
    .out_pending  (out_pending),
    .out_annul    (out_annul),
    .out_target   (out_target),
    .out_link_we  (out_link_we),
    .out_link_idx (out_link_idx)
);

// File: tb/dsb_branch_unit_tb.sv
module dsb_branch_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [1:0]  kind;
        logic        likely;
        logic        link;
        logic        ne;
        logic [2:0]  cmp;
        logic [25:0] field;
        logic [63:0] pc;
        logic [63:0] rs;
        logic [63:0] rt;
        logic        taken;
        logic        annul;
        logic        lnk;
        logic [63:0] tgt;
    } vec_t;

    // kind: 0 jump, 1 jal, 2 eq branch, 3 cmp-zero
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 26'h0000010, 64'h0000_0000_1000_0000, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_1000_0040},
        '{2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 26'h3FFFFFF, 64'h0000_0000_0FFF_FFFC, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_1FFF_FFFC},
        '{2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 26'h0000001, 64'hFFFF_FFFF_F000_0100, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_F000_0004},
        '{2'd2, 1'b0, 1'b1, 1'b0, 3'd0, 26'h0000010, 64'h0000_0000_0000_1000, 64'd5, 64'd5, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_1044},
        '{2'd2, 1'b1, 1'b0, 1'b0, 3'd0, 26'h0000010, 64'h0000_0000_0000_1100, 64'd5, 64'd6, 1'b0, 1'b1, 1'b0, 64'd0},
        '{2'd2, 1'b0, 1'b0, 1'b1, 3'd0, 26'h000FFFF, 64'h0000_0000_0000_2000, 64'd5, 64'd6, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_2000},
        '{2'd2, 1'b0, 1'b0, 1'b1, 3'd0, 26'h0000004, 64'h0000_0000_0000_2100, 64'd7, 64'd7, 1'b0, 1'b0, 1'b0, 64'd0},
        '{2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 26'h0000010, 64'hFFFF_FFFF_FFFF_FFF0, 64'd9, 64'd9, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0034},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd2, 26'h0008000, 64'h0000_0000_0010_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_000E_0004},
        '{2'd3, 1'b1, 1'b1, 1'b0, 3'd5, 26'h0000004, 64'h0000_0000_0000_3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b1, 1'b1, 64'd0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd4, 26'h0000004, 64'h0000_0000_0000_3100, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0},
        '{2'd3, 1'b0, 1'b1, 1'b0, 3'd3, 26'h0000001, 64'h0000_0000_0000_4000, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_4008},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd4, 26'h0000004, 64'h0000_0000_0000_4100, 64'h8000_0000_0000_0000, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd1, 26'h0000002, 64'h0000_0000_0000_5000, 64'd1, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_500C},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd6, 26'h0000004, 64'h0000_0000_0000_5100, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 3'd5, 26'h0000000, 64'h0000_0000_0000_6000, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_6004},
        '{2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 26'h0000003, 64'h0000_0000_0000_7000, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_7010}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_pc = '0;
    logic [1:0]  in_kind = '0;
    logic        in_likely = 1'b0;
    logic        in_link = 1'b0;
    logic        in_ne = 1'b0;
    logic [2:0]  in_cmp = '0;
    logic [25:0] in_field = '0;
    logic [63:0] in_rs = '0;
    logic [63:0] in_rt = '0;
    logic        redirect_ack = 1'b0;
    logic        out_valid;
    logic        out_pending;
    logic        out_annul;
    logic [63:0] out_target;
    logic        out_link_we;
    logic [4:0]  out_link_idx;
    logic [63:0] out_link_val;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_tgt = '0;
    logic [63:0] exp_link = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsb_branch_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_pc        (in_pc),
        .in_kind      (in_kind),
        .in_likely    (in_likely),
        .in_link      (in_link),
        .in_ne        (in_ne),
        .in_cmp       (in_cmp),
        .in_field     (in_field),
        .in_rs        (in_rs),
        .in_rt        (in_rt),
        .redirect_ack (redirect_ack),
        .out_valid    (out_valid),
        .out_pending  (out_pending),
        .out_annul    (out_annul),
        .out_target   (out_target),
        .out_link_we  (out_link_we),
        .out_link_idx (out_link_idx),
        .out_link_val (out_link_val)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_kind   = v.kind;
        in_likely = v.likely;
        in_link   = v.link;
        in_ne     = v.ne;
        in_cmp    = v.cmp;
        in_field  = v.field;
        in_pc     = v.pc;
        in_rs     = v.rs;
        in_rt     = v.rt;
    endtask

    task automatic ack_redirect();
        @(negedge clk);
        redirect_ack = 1'b1;
        @(negedge clk);
        redirect_ack = 1'b0;
        check("R10 pending cleared after ack", 64'(out_pending), 64'd0);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (v.taken) exp_tgt = v.tgt;
        if (v.lnk) exp_link = v.pc + 64'd8;
        $display("vector %0d", idx);
        check("R7 strobe", 64'(out_valid), 64'd1);
        check("R5 R6 R7 taken/pending", 64'(out_pending), 64'(v.taken));
        check("R2 R4 R7 target", out_target, exp_tgt);
        check("R8 annul", 64'(out_annul), 64'(v.annul));
        check("R3 R9 link_we", 64'(out_link_we), 64'(v.lnk));
        check("R3 R9 link_idx", 64'(out_link_idx), v.lnk ? 64'd31 : 64'd0);
        check("R3 R9 link_val", out_link_val, exp_link);
        if (v.taken) ack_redirect();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid in reset", 64'(out_valid), 64'd0);
        check("R1 pending in reset", 64'(out_pending), 64'd0);
        check("R1 target in reset", out_target, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 annul after reset", 64'(out_annul), 64'd0);
        check("R1 link_we after reset", 64'(out_link_we), 64'd0);
        check("R1 link_val after reset", out_link_val, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // R10 hold without ack, R11 ignore while pending
        @(negedge clk);
        drive(VECS[3]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_tgt = VECS[3].tgt;
        check("R7 pending set", 64'(out_pending), 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 pending held", 64'(out_pending), 64'd1);
        end
        drive(VECS[2]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 no strobe while pending", 64'(out_valid), 64'd0);
        check("R11 target kept", out_target, exp_tgt);
        check("R11 no link while pending", 64'(out_link_we), 64'd0);
        check("R11 link_val kept", out_link_val, exp_link);
        check("R10 still pending", 64'(out_pending), 64'd1);
        ack_redirect();

        // back-to-back fall-through branches in IDLE
        run_vec(VECS[10], 100);
        run_vec(VECS[9], 101);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule